// File: doc/BRIEF.md
# Serial Register Access Port

This block is a four-wire serial slave that gives a host read and write access to a bank of 8-bit configuration registers. Each transfer begins when chip select falls. The first byte holds a fixed 7-bit device address and a direction bit. For a write, the next byte loads a register pointer, and every byte after that is stored at the pointer, which then advances. For a read, the block returns the register that the pointer selects, and then the registers that follow it. The pointer was set by an earlier write that ended right after the pointer byte.

All serial pins are synchronised into the system clock domain, and their edges are detected there. The system clock must run at least four times faster than the serial clock. Input bits are taken on the serial clock's rising edge. Output bits change on its falling edge. The serial output comes with an output enable, so a pad can tri-state it. All register contents are also presented in parallel for use by the surrounding logic.

Top module: `spi_regport`

## Requirements
- R1: After reset, every register reads zero and the output enable `misoOe` is low.
- R2: The block responds only when the first seven bits after chip select falls equal 0010000, taken most significant bit first. For any other device address it writes no register and keeps `misoOe` low until chip select rises.
- R3: In a write (bit eight of the first byte is 0), the second byte loads the pointer from its low 7 bits; bit 7 is ignored. Each later byte is stored in the register that the pointer selects, and the pointer then increments.
- R4: A write that ends right after the pointer byte changes no register. The pointer value stays in place across transactions until it is loaded again or advanced.
- R5: In a read (bit eight of the first byte is 1), the falling serial clock edge after that bit raises `misoOe` and presents bit 7 of the selected register on `miso`. Later bits follow on later falling edges, MSB first. After each byte the pointer increments, so consecutive registers follow back to back.
- R6: `misoOe` stays low for the whole of a write transaction.
- R7: The pointer wraps from 127 to 0 during both write and read bursts.
- R8: Chip select rising at any point ends the transaction. It drops `misoOe`, restarts bit counting and discards a partly received byte without writing it.
- R9: If chip select is already low when reset is released, the block ignores serial traffic until chip select has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for `miso` |
| regFlat | output | NUM_REGS*DATA_W | All registers, register n at bits n*8+7..n*8 |

## Verification
The bench targets byte boundaries inside read bursts. There, a design that reloads the output shift register on the rising edge would change `miso` while the host samples it. A design that forgets to advance the pointer would repeat a register. Bursts that start at pointer 126 expose a pointer that fails to wrap. Chip select is dropped in the middle of a data byte; a design that commits partial bytes would then show a corrupted register. Traffic that carries a foreign device address, and traffic sent while chip select was held low through reset, would alter the register image if the design matched addresses loosely or started on a level instead of an edge.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } linkState_t;

  typedef struct packed {
    logic loadPtr;
    logic writeReg;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic oeSet;
    logic oeClr;
  } ctlStrobe_t;

endpackage

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DEV_ADDR_W = 7,
  parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              mosi,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] rxByte
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [2:0] sclkSync;
  logic [2:0] csSync;
  logic [1:0] mosiSync;

  // chip select chain resets low so a select held low through reset gives no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '0;
      mosiSync <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[1:0], csN};
      mosiSync <= {mosiSync[0], mosi};
    end
  end

  logic sclkRise, sclkFall, csFall, csHigh;
  assign sclkRise = sclkSync[1] & ~sclkSync[2];
  assign sclkFall = ~sclkSync[1] & sclkSync[2];
  assign csFall   = ~csSync[1] & csSync[2];
  assign csHigh   = csSync[1];

  linkState_t        state;
  logic [CNT_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftIn;
  logic              loadPend;
  logic              byteDone;
  logic [DATA_W-1:0] nextByte;

  assign nextByte = {shiftIn[DATA_W-2:0], mosiSync[1]};
  assign byteDone = sclkRise && (bitIdx == LAST_BIT);
  assign rxByte   = nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      shiftIn  <= '0;
      loadPend <= 1'b0;
    end else if (csHigh) begin
      state    <= ST_IDLE;
      bitIdx   <= '0;
      loadPend <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (csFall) begin
        state  <= ST_ADDR;
        bitIdx <= '0;
      end
    end else begin
      if (sclkRise) begin
        shiftIn <= nextByte;
        bitIdx  <= bitIdx + 1'b1;
      end
      if (byteDone) begin
        unique case (state)
          ST_ADDR: begin
            if (nextByte[DATA_W-1 -: DEV_ADDR_W] != DEV_ADDR) begin
              state <= ST_SKIP;
            end else if (nextByte[0]) begin
              state    <= ST_RDATA;
              loadPend <= 1'b1;
            end else begin
              state <= ST_PTR;
            end
          end
          ST_PTR:   state <= ST_WDATA;
          ST_RDATA: loadPend <= 1'b1;
          default:  ;
        endcase
      end else if (sclkFall && state == ST_RDATA && loadPend) begin
        loadPend <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.oeClr    = csHigh;
    if (!csHigh) begin
      strobe.loadPtr  = (state == ST_PTR) && byteDone;
      strobe.writeReg = (state == ST_WDATA) && byteDone;
      strobe.incPtr   = (state == ST_WDATA || state == ST_RDATA) && byteDone;
      strobe.loadTx   = (state == ST_RDATA) && sclkFall && loadPend;
      strobe.oeSet    = (state == ST_RDATA) && sclkFall && loadPend;
      strobe.shiftTx  = (state == ST_RDATA) && sclkFall && !loadPend;
    end
  end

endmodule

// File: rtl/spi_regport_dp.sv
module spi_regport_dp
  import spi_regport_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 128
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          rxByte,
  output logic                       miso,
  output logic                       misoOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] txShift;
  logic              oe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (strobe.writeReg) begin
      regs[ptr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= rxByte[PTR_W-1:0];
    end else if (strobe.incPtr) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      oe      <= 1'b0;
    end else begin
      if (strobe.loadTx) begin
        txShift <= regs[ptr];
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
      if (strobe.oeClr) begin
        oe <= 1'b0;
      end else if (strobe.oeSet) begin
        oe <= 1'b1;
      end
    end
  end

  assign miso   = txShift[DATA_W-1];
  assign misoOe = oe;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gFlat
    assign regFlat[g*DATA_W +: DATA_W] = regs[g];
  end

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 128,
  parameter int DEV_ADDR_W = 7,
  parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       mosi,
  output logic                       miso,
  output logic                       misoOe,
  output logic [NUM_REGS*DATA_W-1:0] regFlat
);

  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] rxByte;

  spi_regport_ctrl #(
    .DATA_W    (DATA_W),
    .DEV_ADDR_W(DEV_ADDR_W),
    .DEV_ADDR  (DEV_ADDR)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclk  (sclk),
    .csN   (csN),
    .mosi  (mosi),
    .strobe(strobe),
    .rxByte(rxByte)
  );

  spi_regport_dp #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rxByte (rxByte),
    .miso   (miso),
    .misoOe (misoOe),
    .regFlat(regFlat)
  );

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 128
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclk,
  input logic                       csN,
  input logic                       miso,
  input logic                       misoOe,
  input logic [NUM_REGS*DATA_W-1:0] regFlat
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (regFlat == '0 && !misoOe)); // R1

  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !misoOe); // R8

  AST_REGS_HOLD_ON_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> $stable(regFlat)); // R8

  AST_OE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(misoOe) |-> !csN); // R5

  AST_MISO_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (misoOe && $past(misoOe) && (miso != $past(miso))) |-> !$past(sclk, 2)); // R5

endmodule

bind spi_regport spi_regport_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .sclk   (sclk),
  .csN    (csN),
  .miso   (miso),
  .misoOe (misoOe),
  .regFlat(regFlat)
);

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;

  localparam int DATA_W   = 8;
  localparam int NUM_REGS = 128;
  localparam int HALF     = 6;
  localparam logic [6:0] DEV = 7'b0010000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic mosi = 1'b0;
  logic miso, misoOe;
  logic [NUM_REGS*DATA_W-1:0] regFlat;

  always #2.5 clk = ~clk;

  spi_regport dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .misoOe(misoOe), .regFlat(regFlat)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  bit oeSeen = 1'b0;
  logic [7:0] model [NUM_REGS];
  int expPtr = 0;
  logic [7:0] wbuf [16];

  always @(posedge clk) if (misoOe) oeSeen = 1'b1;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int regMismatch();
    for (int i = 0; i < NUM_REGS; i++)
      if (regFlat[i*8 +: 8] !== model[i]) return i;
    return -1;
  endfunction

  task automatic checkRegs(input string req);
    int bad;
    bad = regMismatch();
    compared++;
    if (bad >= 0) begin
      mismatched++;
      $display("FAIL %s: reg %0d actual %0h expected %0h", req, bad,
               regFlat[bad*8 +: 8], model[bad]);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      waitCyc(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      waitCyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic csStart();
    oeSeen = 1'b0;
    csN = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic csEnd();
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(8);
  endtask

  // write: address byte, pointer byte, then n data bytes from wbuf
  task automatic spiWrite(input logic [6:0] dev, input logic [7:0] ptrByte, input int n);
    logic [7:0] rx;
    csStart();
    xferBits({dev, 1'b0}, 8, rx);
    xferBits(ptrByte, 8, rx);
    for (int i = 0; i < n; i++) xferBits(wbuf[i], 8, rx);
    csEnd();
    if (dev == DEV) begin
      expPtr = int'(ptrByte[6:0]);
      for (int i = 0; i < n; i++) begin
        model[expPtr] = wbuf[i];
        expPtr = (expPtr + 1) % NUM_REGS;
      end
    end
  endtask

  task automatic spiReadCheck(input int n, input string req);
    logic [7:0] rx;
    csStart();
    xferBits({DEV, 1'b1}, 8, rx);
    for (int i = 0; i < n; i++) begin
      xferBits(8'h00, 8, rx);
      check(req, {24'd0, rx}, {24'd0, model[expPtr]});
      expPtr = (expPtr + 1) % NUM_REGS;
    end
    check({req, " oe raised"}, {31'd0, oeSeen}, 32'd1);
    csEnd();
    check({req, " oe dropped"}, {31'd0, misoOe}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    int r;
    r = $urandom(32'd5150);
    for (int i = 0; i < NUM_REGS; i++) model[i] = 8'h00;

    // R9: select held low through reset release
    csN = 1'b0;
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    // R1: reset state
    checkRegs("R1 regs zero");
    check("R1 oe low", {31'd0, misoOe}, 32'd0);

    oeSeen = 1'b0;
    xferBits({DEV, 1'b0}, 8, rx);
    xferBits(8'h05, 8, rx);
    xferBits(8'hAA, 8, rx);
    csEnd();
    checkRegs("R9 no write without select edge");
    check("R9 oe low", {31'd0, oeSeen}, 32'd0);

    // R3/R6: write burst
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    spiWrite(DEV, 8'h8A, 4);   // bit 7 of pointer byte ignored -> reg 10
    checkRegs("R3 write burst");
    check("R6 oe low in write", {31'd0, oeSeen}, 32'd0);

    // R4: pointer-only write, then read
    spiWrite(DEV, 8'h0B, 0);
    checkRegs("R4 pointer-only write changes nothing");
    spiReadCheck(3, "R5 read burst");
    // R4: pointer persists: continue from where previous read stopped
    spiReadCheck(1, "R4 pointer persists");

    // R7: wrap in write and read
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    spiWrite(DEV, 8'd126, 3);
    checkRegs("R7 write wrap");
    spiWrite(DEV, 8'd126, 0);
    spiReadCheck(3, "R7 read wrap");

    // R2: foreign address write and read
    wbuf[0] = 8'hEE;
    spiWrite(7'b0010001, 8'd20, 1);
    checkRegs("R2 foreign write ignored");
    check("R2 oe low foreign write", {31'd0, oeSeen}, 32'd0);
    csStart();
    xferBits({7'b1010000, 1'b1}, 8, rx);
    xferBits(8'h00, 8, rx);
    check("R2 oe low foreign read", {31'd0, oeSeen}, 32'd0);
    csEnd();

    // R8: abort in the middle of a data byte
    csStart();
    xferBits({DEV, 1'b0}, 8, rx);
    xferBits(8'd40, 8, rx);
    xferBits(8'h5A, 4, rx);
    csEnd();
    expPtr = 40;
    checkRegs("R8 partial byte discarded");
    check("R8 oe low", {31'd0, misoOe}, 32'd0);
    // abort during a read drops enable and keeps pointer at next register
    spiWrite(DEV, 8'd10, 0);
    csStart();
    xferBits({DEV, 1'b1}, 8, rx);
    xferBits(8'h00, 3, rx);
    check("R8 oe high mid read", {31'd0, misoOe}, 32'd1);
    csEnd();
    check("R8 oe dropped on abort", {31'd0, misoOe}, 32'd0);
    spiReadCheck(1, "R8 pointer unchanged by aborted read byte");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int kind = int'($urandom_range(0, 2));
      int n = int'($urandom_range(1, 4));
      logic [7:0] p = 8'($urandom_range(0, 255));
      if (kind == 0) begin
        for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
        spiWrite(DEV, p, n);
        checkRegs("R3 random write");
      end else if (kind == 1) begin
        spiWrite(DEV, p, 0);
        spiReadCheck(n, "R5 random read");
      end else begin
        wbuf[0] = 8'($urandom);
        spiWrite(7'($urandom_range(17, 127)), p, 1);
        checkRegs("R2 random foreign write");
      end
    end
    spiReadCheck(2, "R4 pointer after random traffic");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule